// File: doc/BRIEF.md
# Software interrupt source tracker

This block keeps, for every software-generated interrupt (SGI) number and every target core, a small bitmap of the source cores that have raised that SGI toward that target. A core raises SGIs through a generation port by giving an SGI number, a mask of target cores and its own core ID. Software on any core can inspect and edit its own bitmaps through a byte-wide register window. One region of the window sets source bits and another clears them. The block drives a per-core, per-SGI pending flag to an external prioritizer.

When a core acknowledges an SGI that the prioritizer has selected, the block returns the SGI number with the lowest-numbered source core that is still recorded. It removes only that source. The SGI stays pending on that core until every source has been acknowledged or cleared, so successive acknowledges return the sources one at a time, lowest first. Arbitration between interrupts, the running-priority compare and end-of-interrupt handling belong to the prioritizer and are not part of this block.

Top module: `sgi_src_tracker`

## Requirements
- R1: A generation write with SGI number s, target mask m and source ID n sets bit n of the source vector (s, t) for every core t whose bit is set in m. It also sets the pending flag `pend[t*16+s]` one cycle later.
- R2: An acknowledge by core c of SGI number s (0..15) with `ack_no_valid` low returns {lowest set source index in bits [12:10], s in bits [9:0]} in the same cycle. From the next cycle on, only that one source bit is cleared. An empty vector returns source 0.
- R3: After an SGI acknowledge, the pending flag of (s, c) stays set while any source bit remains, and it is cleared once the vector has become all zeros.
- R4: A write of byte v to window offset 0x10+s by core c clears the bits of v in vector (s, c). It clears the pending flag only if the vector becomes zero.
- R5: A write of byte v to offset 0x20+s by core c ORs v into vector (s, c) and sets its pending flag, even when v is zero.
- R6: A read of offset 0x10+s or 0x20+s by core c returns vector (s, c) combinationally on `reg_rdata`.
- R7: When `ack_no_valid` is high, the acknowledge returns 1023 with source field 0 and changes no vector or pending flag.
- R8: An acknowledge of an ID of 16 or above returns that ID with source field 0 and leaves every source vector unchanged.
- R9: When a set-pending or generation write and an acknowledge reach the same vector in one cycle, the result is (old & ~acked bit) | set bits, and the pending flag stays set.
- R10: Reads of offsets outside 0x10..0x2F return 0, and writes there change no state.
- R11: While `rst_n` is low at a clock edge, all vectors and pending flags are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| gen_valid | input | 1 | Generation write strobe |
| gen_sgi | input | 4 | SGI number being raised |
| gen_targets | input | 8 | Target core mask |
| gen_src | input | 3 | ID of the core raising the SGI |
| reg_valid | input | 1 | Register window access strobe |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_core | input | 3 | ID of the accessing core |
| reg_addr | input | 8 | Byte offset in the window |
| reg_wdata | input | 8 | Write byte |
| reg_rdata | output | 8 | Read byte (combinational) |
| ack_req | input | 8 | Per-core acknowledge strobe |
| ack_id | input | 80 | Per-core selected interrupt ID, 10 bits per core |
| ack_no_valid | input | 8 | Per-core: nothing eligible for acknowledge |
| ack_data | output | 104 | Per-core acknowledge result, 13 bits per core |
| pend | output | 128 | Pending flag of SGI s on core c at bit c*16+s |

## Verification
The hardest case to reach is one vector receiving a new source and losing its lowest source in the same cycle. Random traffic seldom lines up the generation port, the register port and an acknowledge on the same SGI and core. The stimulus forces this case with a directed step that drives all three at once. It also confines random SGI numbers to a few values so that such collisions recur. A second hard state is a pending flag with an empty vector. A set-pending write of zero reaches it, and a later acknowledge then drains it.

// File: rtl/sgi_pkg.sv
// Shared constants and types for the SGI source tracker.
// Assumes the architectural acknowledge format: ID in [9:0], source in [12:10].
package sgi_pkg;
    localparam int ID_W        = 10;
    localparam int SRC_FIELD_W = 3;
    localparam int ACK_W       = ID_W + SRC_FIELD_W;
    localparam int BYTE_W      = 8;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;

    typedef enum logic [1:0] {
        RK_NONE = 2'd0,
        RK_CLR  = 2'd1,
        RK_SET  = 2'd2
    } reg_kind_e;
endpackage

// File: rtl/sgi_lowest_pick.sv
// Finds the lowest set bit of a vector and returns it as an index and a one-hot mask.
// Assumes W >= 1; an all-zero vector yields index 0 and an empty mask.
module sgi_lowest_pick #(
    parameter int W  = 8,
    parameter int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic [W-1:0]  onehot,
    output logic          any
);
    // Scan from the top down so the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) begin
                idx = IW'(i);
            end
        end
        any    = |vec;
        onehot = any ? ({{(W-1){1'b0}}, 1'b1} << idx) : '0;
    end
endmodule

// File: rtl/sgi_reg_decode.sv
// Decodes a window byte offset into a clear region, a set region or nothing,
// and gives the SGI number addressed. Assumes the two regions do not overlap.
module sgi_reg_decode
    import sgi_pkg::*;
#(
    parameter int NSGI     = 16,
    parameter int ADDR_W   = 8,
    parameter int CLR_BASE = 16,
    parameter int SET_BASE = 32,
    parameter int SGI_W    = (NSGI > 1) ? $clog2(NSGI) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [SGI_W-1:0]  sgi
);
    // Compare against every offset of both regions.
    always_comb begin
        kind = RK_NONE;
        sgi  = '0;
        for (int s = 0; s < NSGI; s++) begin
            if (addr == ADDR_W'(CLR_BASE + s)) begin
                kind = RK_CLR;
                sgi  = SGI_W'(s);
            end
            if (addr == ADDR_W'(SET_BASE + s)) begin
                kind = RK_SET;
                sgi  = SGI_W'(s);
            end
        end
    end
endmodule

// File: rtl/sgi_ack_unit.sv
// Per-core acknowledge logic: forms the returned word and the source bit to drop.
// Assumes the prioritizer flags no_valid when nothing may be acknowledged.
module sgi_ack_unit
    import sgi_pkg::*;
#(
    parameter int NCORE = 8,
    parameter int NSGI  = 16,
    parameter int SRC_W = (NCORE > 1) ? $clog2(NCORE) : 1,
    parameter int SGI_W = (NSGI > 1) ? $clog2(NSGI) : 1
) (
    input  logic                  req,
    input  logic                  no_valid,
    input  logic [ID_W-1:0]       id,
    input  logic [NSGI*NCORE-1:0] row,
    output logic [ACK_W-1:0]      data,
    output logic [NSGI*NCORE-1:0] clr_row,
    output logic [NSGI-1:0]       clr_evt
);
    logic             is_sgi;
    logic [SGI_W-1:0] id_sgi;
    logic [NCORE-1:0] sel_vec;
    logic [SRC_W-1:0] src_idx;
    logic [NCORE-1:0] src_onehot;
    logic             src_any;
    logic [SRC_FIELD_W-1:0] src_field;
    logic             hit;

    // Select this core's vector for the acknowledged SGI number.
    always_comb begin
        is_sgi  = (id < ID_W'(NSGI));
        id_sgi  = SGI_W'(id);
        sel_vec = row[int'(id_sgi)*NCORE +: NCORE];
    end

    sgi_lowest_pick #(.W(NCORE), .IW(SRC_W)) u_pick (
        .vec    (sel_vec),
        .idx    (src_idx),
        .onehot (src_onehot),
        .any    (src_any)
    );

    // Build the returned word: spurious, SGI with source, or pass-through.
    always_comb begin
        src_field = '0;
        src_field[SRC_W-1:0] = src_idx;
        if (no_valid) begin
            data = {{SRC_FIELD_W{1'b0}}, SPURIOUS_ID};
        end else if (is_sgi) begin
            data = {src_any ? src_field : {SRC_FIELD_W{1'b0}}, id};
        end else begin
            data = {{SRC_FIELD_W{1'b0}}, id};
        end
    end

    // Route the bit to drop to the acknowledged SGI's cell only.
    always_comb begin
        hit = req && !no_valid && is_sgi;
        for (int s = 0; s < NSGI; s++) begin
            clr_evt[s]                  = hit && (id_sgi == SGI_W'(s));
            clr_row[s*NCORE +: NCORE]   = clr_evt[s] ? src_onehot : '0;
        end
    end
endmodule

// File: rtl/sgi_cell.sv
// Holds one source vector and its pending flag for one (SGI, target core) pair.
// Set bits win over cleared bits in the same cycle; a set event keeps the flag.
module sgi_cell #(
    parameter int NCORE = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NCORE-1:0] set_bits,
    input  logic [NCORE-1:0] clr_bits,
    input  logic             set_evt,
    input  logic             clr_evt,
    output logic [NCORE-1:0] vec,
    output logic             flag
);
    logic [NCORE-1:0] vec_nxt;
    logic             flag_nxt;

    // Merge all same-cycle updates into one next state.
    always_comb begin
        vec_nxt = (vec & ~clr_bits) | set_bits;
        if (set_evt) begin
            flag_nxt = 1'b1;
        end else if (clr_evt && (vec_nxt == '0)) begin
            flag_nxt = 1'b0;
        end else begin
            flag_nxt = flag;
        end
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec  <= '0;
            flag <= 1'b0;
        end else begin
            vec  <= vec_nxt;
            flag <= flag_nxt;
        end
    end
endmodule

// File: rtl/sgi_src_tracker.sv
// Top of the SGI source tracker: a grid of NCORE x NSGI source vectors fed by
// the generation port, the register window and one acknowledge unit per core.
// Assumes NCORE <= 8 so a source vector fits in one window byte.
module sgi_src_tracker
    import sgi_pkg::*;
#(
    parameter int NCORE    = 8,
    parameter int NSGI     = 16,
    parameter int ADDR_W   = 8,
    parameter int CLR_BASE = 16,
    parameter int SET_BASE = 32,
    parameter int SRC_W    = (NCORE > 1) ? $clog2(NCORE) : 1,
    parameter int SGI_W    = (NSGI > 1) ? $clog2(NSGI) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    gen_valid,
    input  logic [SGI_W-1:0]        gen_sgi,
    input  logic [NCORE-1:0]        gen_targets,
    input  logic [SRC_W-1:0]        gen_src,
    input  logic                    reg_valid,
    input  logic                    reg_write,
    input  logic [SRC_W-1:0]        reg_core,
    input  logic [ADDR_W-1:0]       reg_addr,
    input  logic [BYTE_W-1:0]       reg_wdata,
    output logic [BYTE_W-1:0]       reg_rdata,
    input  logic [NCORE-1:0]        ack_req,
    input  logic [NCORE*ID_W-1:0]   ack_id,
    input  logic [NCORE-1:0]        ack_no_valid,
    output logic [NCORE*ACK_W-1:0]  ack_data,
    output logic [NCORE*NSGI-1:0]   pend
);
    localparam int CELLS = NCORE * NSGI;

    reg_kind_e             rk;
    logic [SGI_W-1:0]      rk_sgi;
    logic [CELLS*NCORE-1:0] vec_flat;
    logic [CELLS*NCORE-1:0] ack_clr_flat;
    logic [CELLS-1:0]      ack_evt_flat;
    logic [NCORE-1:0]      gen_bit;
    logic [NCORE-1:0]      wbyte;

    sgi_reg_decode #(
        .NSGI(NSGI), .ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE),
        .SET_BASE(SET_BASE), .SGI_W(SGI_W)
    ) u_dec (
        .addr (reg_addr),
        .kind (rk),
        .sgi  (rk_sgi)
    );

    // Source bit of the generating core and the write byte trimmed to core count.
    always_comb begin
        gen_bit = {{(NCORE-1){1'b0}}, 1'b1} << gen_src;
        wbyte   = reg_wdata[NCORE-1:0];
    end

    // Window read: the accessing core's vector for the addressed SGI, else zero.
    always_comb begin
        reg_rdata = '0;
        if (reg_valid && !reg_write && (rk != RK_NONE)) begin
            reg_rdata[NCORE-1:0] =
                vec_flat[(int'(reg_core)*NSGI + int'(rk_sgi))*NCORE +: NCORE];
        end
    end

    for (genvar c = 0; c < NCORE; c++) begin : g_core
        sgi_ack_unit #(
            .NCORE(NCORE), .NSGI(NSGI), .SRC_W(SRC_W), .SGI_W(SGI_W)
        ) u_ack (
            .req      (ack_req[c]),
            .no_valid (ack_no_valid[c]),
            .id       (ack_id[c*ID_W +: ID_W]),
            .row      (vec_flat[c*NSGI*NCORE +: NSGI*NCORE]),
            .data     (ack_data[c*ACK_W +: ACK_W]),
            .clr_row  (ack_clr_flat[c*NSGI*NCORE +: NSGI*NCORE]),
            .clr_evt  (ack_evt_flat[c*NSGI +: NSGI])
        );

        for (genvar s = 0; s < NSGI; s++) begin : g_sgi
            logic             gen_hit;
            logic             wset_hit;
            logic             wclr_hit;
            logic [NCORE-1:0] set_bits;
            logic [NCORE-1:0] clr_bits;

            // Gather every source of change aimed at this cell.
            always_comb begin
                gen_hit  = gen_valid && gen_targets[c] && (gen_sgi == SGI_W'(s));
                wset_hit = reg_valid && reg_write && (reg_core == SRC_W'(c))
                           && (rk == RK_SET) && (rk_sgi == SGI_W'(s));
                wclr_hit = reg_valid && reg_write && (reg_core == SRC_W'(c))
                           && (rk == RK_CLR) && (rk_sgi == SGI_W'(s));
                set_bits = (gen_hit ? gen_bit : '0) | (wset_hit ? wbyte : '0);
                clr_bits = ack_clr_flat[(c*NSGI+s)*NCORE +: NCORE]
                           | (wclr_hit ? wbyte : '0);
            end

            sgi_cell #(.NCORE(NCORE)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .set_bits (set_bits),
                .clr_bits (clr_bits),
                .set_evt  (gen_hit || wset_hit),
                .clr_evt  (wclr_hit || ack_evt_flat[c*NSGI+s]),
                .vec      (vec_flat[(c*NSGI+s)*NCORE +: NCORE]),
                .flag     (pend[c*NSGI+s])
            );
        end
    end
endmodule

// File: rtl/sgi_src_tracker_chk.sv
// Port-level checker for the SGI source tracker, attached by bind.
module sgi_src_tracker_chk
    import sgi_pkg::*;
#(
    parameter int NCORE    = 8,
    parameter int NSGI     = 16,
    parameter int ADDR_W   = 8,
    parameter int CLR_BASE = 16,
    parameter int SET_BASE = 32,
    parameter int SRC_W    = 3,
    parameter int SGI_W    = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   gen_valid,
    input logic [SGI_W-1:0]       gen_sgi,
    input logic [NCORE-1:0]       gen_targets,
    input logic                   reg_valid,
    input logic                   reg_write,
    input logic [SRC_W-1:0]       reg_core,
    input logic [ADDR_W-1:0]      reg_addr,
    input logic [BYTE_W-1:0]      reg_rdata,
    input logic [NCORE-1:0]       ack_req,
    input logic [NCORE*ID_W-1:0]  ack_id,
    input logic [NCORE-1:0]       ack_no_valid,
    input logic [NCORE*ACK_W-1:0] ack_data,
    input logic [NCORE*NSGI-1:0]  pend
);
    logic [NCORE*NSGI-1:0] must_set_q;
    logic                  in_window;

    // Record which pending flags the last cycle's set traffic demands.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            must_set_q <= '0;
        end else begin
            for (int c = 0; c < NCORE; c++) begin
                for (int s = 0; s < NSGI; s++) begin
                    must_set_q[c*NSGI+s] <=
                        (gen_valid && gen_targets[c] && (gen_sgi == SGI_W'(s))) ||
                        (reg_valid && reg_write && (reg_core == SRC_W'(c)) &&
                         (reg_addr == ADDR_W'(SET_BASE + s)));
                end
            end
        end
    end

    // Whether the current offset falls in either SGI region.
    always_comb begin
        in_window = 1'b0;
        for (int s = 0; s < NSGI; s++) begin
            if (reg_addr == ADDR_W'(CLR_BASE + s) || reg_addr == ADDR_W'(SET_BASE + s)) begin
                in_window = 1'b1;
            end
        end
    end

    p_set_pend_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (pend & must_set_q) == must_set_q);

    p_oob_read_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_valid && !reg_write && !in_window) |-> (reg_rdata == '0));

    p_reset_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (pend == '0));

    for (genvar c = 0; c < NCORE; c++) begin : g_ack
        p_spurious_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_req[c] && ack_no_valid[c]) |->
            (ack_data[c*ACK_W +: ACK_W] == {{SRC_FIELD_W{1'b0}}, SPURIOUS_ID}));

        p_pass_through_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_req[c] && !ack_no_valid[c] && (ack_id[c*ID_W +: ID_W] >= ID_W'(NSGI))) |->
            (ack_data[c*ACK_W +: ACK_W] == {{SRC_FIELD_W{1'b0}}, ack_id[c*ID_W +: ID_W]}));

        p_sgi_id_field_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_req[c] && !ack_no_valid[c] && (ack_id[c*ID_W +: ID_W] < ID_W'(NSGI))) |->
            (ack_data[c*ACK_W +: ID_W] == ack_id[c*ID_W +: ID_W]));
    end
endmodule

bind sgi_src_tracker sgi_src_tracker_chk #(
    .NCORE(NCORE), .NSGI(NSGI), .ADDR_W(ADDR_W), .CLR_BASE(CLR_BASE),
    .SET_BASE(SET_BASE), .SRC_W(SRC_W), .SGI_W(SGI_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gen_valid    (gen_valid),
    .gen_sgi      (gen_sgi),
    .gen_targets  (gen_targets),
    .reg_valid    (reg_valid),
    .reg_write    (reg_write),
    .reg_core     (reg_core),
    .reg_addr     (reg_addr),
    .reg_rdata    (reg_rdata),
    .ack_req      (ack_req),
    .ack_id       (ack_id),
    .ack_no_valid (ack_no_valid),
    .ack_data     (ack_data),
    .pend         (pend)
);

// File: tb/tb_sgi_src_tracker.sv
module tb_sgi_src_tracker;
    localparam int NC = 8;
    localparam int NS = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          gen_valid = 1'b0;
    logic [3:0]    gen_sgi = '0;
    logic [7:0]    gen_targets = '0;
    logic [2:0]    gen_src = '0;
    logic          reg_valid = 1'b0;
    logic          reg_write = 1'b0;
    logic [2:0]    reg_core = '0;
    logic [7:0]    reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic [7:0]    ack_req = '0;
    logic [79:0]   ack_id = '0;
    logic [7:0]    ack_no_valid = '0;
    logic [103:0]  ack_data;
    logic [127:0]  pend;

    logic [7:0] mv [NC][NS];
    logic       mf [NC][NS];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    sgi_src_tracker dut (
        .clk(clk), .rst_n(rst_n),
        .gen_valid(gen_valid), .gen_sgi(gen_sgi), .gen_targets(gen_targets), .gen_src(gen_src),
        .reg_valid(reg_valid), .reg_write(reg_write), .reg_core(reg_core),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .ack_req(ack_req), .ack_id(ack_id), .ack_no_valid(ack_no_valid),
        .ack_data(ack_data), .pend(pend)
    );

    always #10 clk = ~clk;

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int lowest(input logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [12:0] exp_ack(input int c);
        logic [9:0] id;
        id = ack_id[c*10 +: 10];
        if (ack_no_valid[c]) return {3'd0, 10'd1023};
        if (id >= 10'd16) return {3'd0, id};
        return {3'(lowest(mv[c][id[3:0]])), id};
    endfunction

    function automatic logic [7:0] exp_rd();
        if (!reg_valid || reg_write) return 8'h00;
        if (reg_addr >= 8'h10 && reg_addr < 8'h30) return mv[reg_core][reg_addr[3:0]];
        return 8'h00;
    endfunction

    function automatic logic [127:0] model_pend();
        logic [127:0] p;
        for (int c = 0; c < NC; c++)
            for (int s = 0; s < NS; s++) p[c*NS+s] = mf[c][s];
        return p;
    endfunction

    task automatic model_update();
        for (int c = 0; c < NC; c++) begin
            for (int s = 0; s < NS; s++) begin
                logic [7:0] setb, clrb, nv;
                logic sev, cev;
                setb = 0; clrb = 0; sev = 0; cev = 0;
                if (gen_valid && gen_targets[c] && gen_sgi == 4'(s)) begin
                    setb |= 8'(1) << gen_src; sev = 1;
                end
                if (reg_valid && reg_write && reg_core == 3'(c)) begin
                    if (reg_addr == 8'(32 + s)) begin setb |= reg_wdata; sev = 1; end
                    if (reg_addr == 8'(16 + s)) begin clrb |= reg_wdata; cev = 1; end
                end
                if (ack_req[c] && !ack_no_valid[c] && ack_id[c*10 +: 10] == 10'(s)) begin
                    if (mv[c][s] != 0) clrb |= 8'(1) << lowest(mv[c][s]);
                    cev = 1;
                end
                nv = (mv[c][s] & ~clrb) | setb;
                if (!rst_n) begin
                    mv[c][s] = 0; mf[c][s] = 0;
                end else begin
                    if (sev) mf[c][s] = 1;
                    else if (cev && nv == 0) mf[c][s] = 0;
                    mv[c][s] = nv;
                end
            end
        end
    endtask

    task automatic idle();
        gen_valid = 0; reg_valid = 0; reg_write = 0; ack_req = 0; ack_no_valid = 0;
    endtask

    // Called just after a falling edge with inputs set; checks combinational
    // outputs, crosses one rising edge, then checks the pending flags.
    task automatic step(input string ptag);
        #2;
        for (int c = 0; c < NC; c++) begin
            if (ack_req[c]) begin
                if (ack_no_valid[c]) chk("R7 spurious ack", 128'(ack_data[c*13 +: 13]), 128'(exp_ack(c)));
                else if (ack_id[c*10 +: 10] >= 10'd16) chk("R8 pass-through ack", 128'(ack_data[c*13 +: 13]), 128'(exp_ack(c)));
                else chk("R2 lowest source ack", 128'(ack_data[c*13 +: 13]), 128'(exp_ack(c)));
            end
        end
        if (reg_valid && !reg_write) begin
            if (reg_addr >= 8'h10 && reg_addr < 8'h30) chk("R6 window read", 128'(reg_rdata), 128'(exp_rd()));
            else chk("R10 out-of-window read", 128'(reg_rdata), 128'(exp_rd()));
        end
        @(posedge clk);
        model_update();
        @(negedge clk);
        chk(ptag, pend, model_pend());
        idle();
    endtask

    task automatic do_gen(input int s, input logic [7:0] t, input int src);
        gen_valid = 1; gen_sgi = 4'(s); gen_targets = t; gen_src = 3'(src);
    endtask

    task automatic do_reg(input bit wr, input int core, input logic [7:0] a, input logic [7:0] d);
        reg_valid = 1; reg_write = wr; reg_core = 3'(core); reg_addr = a; reg_wdata = d;
    endtask

    task automatic do_ack(input int core, input int id, input bit nv);
        ack_req[core] = 1; ack_id[core*10 +: 10] = 10'(id); ack_no_valid[core] = nv;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5A17));
        for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) begin mv[c][s] = 0; mf[c][s] = 0; end
        @(negedge clk);
        step("R11 reset clears pending");
        step("R11 reset clears pending");
        rst_n = 1;

        // R1: source 5 raises SGI 3 on cores 0 and 3, then source 2 on core 3
        do_gen(3, 8'b0000_1001, 5); step("R1 generation sets pending");
        do_gen(3, 8'b0000_1000, 2); step("R1 second source");
        do_reg(0, 3, 8'h23, 0); step("R6 read after generation");
        // R2/R3: lowest source first, flag kept until last source leaves
        do_ack(3, 3, 0); step("R3 still pending after first ack");
        do_reg(0, 3, 8'h13, 0); step("R2 only lowest bit cleared");
        do_ack(3, 3, 0); step("R3 cleared after last ack");
        // R7: spurious ack changes nothing
        do_ack(0, 3, 1); step("R7 no state change");
        do_reg(0, 0, 8'h13, 0); step("R7 vector intact");
        // R5/R8: set byte, then non-SGI ack 16 must not touch SGI 0
        do_reg(1, 1, 8'h20, 8'h81); step("R5 set-pending byte");
        do_ack(1, 16, 0); step("R8 non-SGI ack leaves flags");
        do_ack(1, 600, 0); step("R8 non-SGI ack leaves flags");
        do_reg(0, 1, 8'h10, 0); step("R8 vector untouched");
        // R4: partial then full clear
        do_reg(1, 1, 8'h10, 8'h01); step("R4 partial clear keeps pending");
        do_reg(0, 1, 8'h20, 0); step("R4 read after partial clear");
        do_reg(1, 1, 8'h10, 8'h80); step("R4 full clear drops pending");
        // R5: zero byte still sets pending; then ack of empty vector drains it
        do_reg(1, 2, 8'h25, 8'h00); step("R5 zero byte sets pending");
        do_ack(2, 5, 0); step("R3 empty-vector ack clears flag");
        // R10: writes outside the window
        do_reg(1, 2, 8'h30, 8'hFF); step("R10 write ignored");
        do_reg(1, 2, 8'h0F, 8'hFF); step("R10 write ignored");
        do_reg(1, 2, 8'hFF, 8'hFF); step("R10 write ignored");
        do_reg(0, 2, 8'h30, 0); step("R10 read zero");
        do_reg(0, 2, 8'h2F, 0); step("R10 neighbour vector untouched");
        // R9: generation, set byte and ack collide on core 4 SGI 7
        do_gen(7, 8'b0001_0000, 1); step("R9 setup");
        do_gen(7, 8'b0001_0000, 1); do_reg(1, 4, 8'h27, 8'h08); do_ack(4, 7, 0);
        step("R9 merged update keeps pending");
        do_reg(0, 4, 8'h17, 0); step("R9 merged vector");

        // Random traffic on a few SGI numbers to force collisions
        for (int n = 0; n < 3000; n++) begin
            if ($urandom_range(0, 9) < 3) do_gen($urandom_range(0, 3), 8'($urandom), $urandom_range(0, 7));
            if ($urandom_range(0, 9) < 5) begin
                int k;
                logic [7:0] a;
                k = $urandom_range(0, 9);
                a = (k < 4) ? 8'(16 + $urandom_range(0, 3)) :
                    (k < 8) ? 8'(32 + $urandom_range(0, 3)) : 8'($urandom);
                do_reg($urandom_range(0, 1), $urandom_range(0, 7), a, 8'($urandom));
            end
            for (int c = 0; c < NC; c++) begin
                if ($urandom_range(0, 9) < 4) begin
                    int id;
                    id = ($urandom_range(0, 9) < 8) ? $urandom_range(0, 3) : $urandom_range(16, 1023);
                    do_ack(c, id, $urandom_range(0, 9) < 2);
                end
            end
            step("R1/R3 random pending flags");
        end

        // R11: reset in mid-run clears everything
        do_gen(1, 8'hFF, 6);
        step("R11 setup");
        rst_n = 0; step("R11 mid-run reset");
        rst_n = 1;
        do_reg(0, 6, 8'h21, 0); step("R11 vector cleared");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule